// File: doc/BRIEF.md
# I2C Target Receive Acknowledge Engine

This block sits behind the open-drain SCL and SDA pins of an I2C target. It samples both lines in the system clock domain and detects START and STOP. It shifts in each byte MSB first. At the eighth falling edge of SCL it decides whether the ninth clock carries an ACK (SDA pulled low) or a NACK (SDA left high). The first byte after a START is compared against a 7-bit local address. A match is always acknowledged. An extension code is acknowledged only when software has enabled acknowledges. Any other address is ignored until the next START or STOP. Data bytes in the receive direction are acknowledged according to the acknowledge-enable input.

Software chooses where the block stretches the clock. The hold point can come right after the eighth clock, in which case the acknowledge decision stays open for the whole hold. It can instead come after the ninth clock, in which case the decision is taken from the enable bit at the eighth falling edge. A release pulse ends the hold. In the transmit direction the block does not drive the acknowledge slot. It records whether the far side returned ACK.

Top module: `i2c_ack_rx`

## Requirements
- R1: A START (SDA falling while SCL is high) sets `busy`. A STOP (SDA rising while SCL is high) clears `busy`, `addr_match` and `ext_hit`, and releases both pull-low outputs.
- R2: When bits 7..1 of the first byte after START equal `own_addr`, SDA is pulled low from the eighth SCL falling edge until the ninth, whatever `ack_en` holds, and `addr_match` goes to 1.
- R3: When the address byte neither matches nor is an extension code, the ninth clock is a NACK and SCL is not held. Later bytes are then neither acknowledged nor stretched until the next START or STOP.
- R4: An extension code is an address whose upper four bits are 1111 and which differs from `own_addr`. It is acknowledged only if `ack_en` is 1 at the eighth falling edge, and in that case `ext_hit` goes to 1.
- R5: Bit 0 of the address byte (the eighth bit received) is copied to `tx_dir` when the address is accepted. 0 means the target receives.
- R6: In the receive direction, `rx_byte` holds each accepted data byte MSB first, and the ninth clock is an ACK exactly when `ack_en` permits it.
- R7: With `wait_sel` = 0, SCL is held low from the eighth falling edge of every accepted byte. During that hold, SDA follows `ack_en` for a receive data byte. The value present at release is kept through the ninth clock.
- R8: With `wait_sel` = 1, SCL is not held after the eighth clock. The data acknowledge is taken from `ack_en` at the eighth falling edge, and SCL is held low after the ninth falling edge.
- R9: A `wait_rel` pulse during a hold drops `scl_pull` at the next clock edge.
- R10: In the transmit direction the block leaves SDA released on the ninth clock of data bytes. `ack_det` becomes the inverse of SDA sampled at that clock's rising edge.
- R11: The SDA pull-low for an acknowledge ends after the ninth SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL pin level, asynchronous |
| sda_in | input | 1 | SDA pin level, asynchronous |
| own_addr | input | 7 | Local 7-bit address |
| ack_en | input | 1 | Acknowledge enable for data bytes and extension codes |
| wait_sel | input | 1 | Hold point: 0 after the eighth clock, 1 after the ninth |
| wait_rel | input | 1 | Pulse that ends a clock hold |
| sda_pull | output | 1 | Drive SDA low (open drain) |
| scl_pull | output | 1 | Drive SCL low (open drain) |
| rx_byte | output | 8 | Last byte received |
| addr_match | output | 1 | Own address accepted in this transfer |
| ext_hit | output | 1 | Extension code accepted in this transfer |
| busy | output | 1 | Bus between START and STOP |
| tx_dir | output | 1 | Direction bit of the accepted address |
| ack_det | output | 1 | Far side returned ACK on the last transmitted byte |

## Verification
The hardest case to reach from the ports is a change of `ack_en` that lands inside the acknowledge window, after the eighth falling edge but before the ninth rising edge. Under the eighth-clock hold that change must reach SDA, and under the ninth-clock hold it must not. The bench gets there with an open-drain bus model in which the master waits for SCL to actually rise, so the block's hold freezes the master. The bench flips `ack_en` during the frozen interval and only then issues the release pulse. It then clocks the ninth bit and reads the wired SDA level.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;

    localparam int unsigned I2C_ADDR_W = 7;
    localparam int unsigned I2C_DATA_W = 8;
    localparam int unsigned EXT_W      = 4;
    localparam logic [EXT_W-1:0] EXT_PREFIX = '1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    // synchronized line levels and the events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // byte-slot events produced by the bit counter
    typedef struct packed {
        logic byte_end;   // eighth SCL falling edge
        logic ack_rise;   // ninth SCL rising edge
        logic ack_fall;   // ninth SCL falling edge
    } slot_ev_t;

    function automatic logic addr_ack(input logic own, input logic ext, input logic en);
        return own || (ext && en);
    endfunction

endpackage

// File: rtl/i2c_ack_sync.sv
module i2c_ack_sync
    import i2c_ack_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s && !scl_d;
        ev.scl_fall = !scl_s && scl_d;
        ev.start    = scl_s && scl_d && sda_d && !sda_s;
        ev.stop     = scl_s && scl_d && !sda_d && sda_s;
    end
endmodule

// File: rtl/i2c_ack_shift.sv
module i2c_ack_shift
    import i2c_ack_pkg::*;
#(
    parameter int unsigned DATA_W = I2C_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    output logic [DATA_W-1:0] shreg,
    output slot_ev_t          slot
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ACKC = CNT_W'(DATA_W + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (ev.start || ev.stop) begin
            cnt <= '0;
        end else if (ev.scl_rise) begin
            if (cnt < FULL) begin
                shreg <= {shreg[DATA_W-2:0], ev.sda};
                cnt   <= cnt + 1'b1;
            end else if (cnt == FULL) begin
                cnt <= ACKC;
            end
        end else if (ev.scl_fall && cnt == ACKC) begin
            cnt <= '0;
        end
    end

    always_comb begin
        slot.byte_end = ev.scl_fall && (cnt == FULL) && ev.scl == 1'b0;
        slot.ack_rise = ev.scl_rise && (cnt == FULL);
        slot.ack_fall = ev.scl_fall && (cnt == ACKC);
    end
endmodule

// File: rtl/i2c_ack_ctl.sv
module i2c_ack_ctl
    import i2c_ack_pkg::*;
#(
    parameter int unsigned ADDR_W = I2C_ADDR_W,
    parameter int unsigned DATA_W = I2C_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  slot_ev_t          slot,
    input  logic [DATA_W-1:0] shreg,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_en,
    input  logic              wait_sel,
    input  logic              wait_rel,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic [DATA_W-1:0] rx_byte,
    output logic              addr_match,
    output logic              ext_hit,
    output logic              busy,
    output logic              tx_dir,
    output logic              ack_det
);
    localparam int unsigned RW_POS = DATA_W - ADDR_W - 1;

    phase_e            phase_q;
    logic              ack_q, stall_q, track_q, wsel_q, txb_q;
    logic              match_q, ext_q, busy_q, tx_q, ackd_q;
    logic [DATA_W-1:0] rx_q;
    logic [ADDR_W-1:0] rcv_addr;
    logic              own_hit, ext_code, rw_bit;

    assign rcv_addr = shreg[DATA_W-1 -: ADDR_W];
    assign rw_bit   = shreg[RW_POS];
    assign own_hit  = (rcv_addr == own_addr);
    assign ext_code = (rcv_addr[ADDR_W-1 -: EXT_W] == EXT_PREFIX) && !own_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ack_q   <= 1'b0;
            stall_q <= 1'b0;
            track_q <= 1'b0;
            wsel_q  <= 1'b0;
            txb_q   <= 1'b0;
            match_q <= 1'b0;
            ext_q   <= 1'b0;
            busy_q  <= 1'b0;
            tx_q    <= 1'b0;
            ackd_q  <= 1'b0;
            rx_q    <= '0;
        end else if (ev.start || ev.stop) begin
            phase_q <= ev.start ? PH_ADDR : PH_IDLE;
            busy_q  <= ev.start;
            match_q <= 1'b0;
            ext_q   <= 1'b0;
            tx_q    <= 1'b0;
            ack_q   <= 1'b0;
            stall_q <= 1'b0;
            track_q <= 1'b0;
            txb_q   <= 1'b0;
        end else begin
            // hold release, or live tracking of the enable during an eighth-clock hold
            if (stall_q && wait_rel) begin
                stall_q <= 1'b0;
                track_q <= 1'b0;
            end else if (track_q) begin
                ack_q <= ack_en;
            end

            if (slot.byte_end) begin
                wsel_q <= wait_sel;
                case (phase_q)
                    PH_ADDR: begin
                        rx_q <= shreg;
                        if (addr_ack(own_hit, ext_code, ack_en)) begin
                            phase_q <= PH_DATA;
                            match_q <= own_hit;
                            ext_q   <= ext_code;
                            tx_q    <= rw_bit;
                            ack_q   <= 1'b1;
                            stall_q <= !wait_sel;
                        end else begin
                            phase_q <= PH_SKIP;
                            ack_q   <= 1'b0;
                        end
                    end
                    PH_DATA: begin
                        if (!tx_q) rx_q <= shreg;
                        ack_q   <= !tx_q && ack_en;
                        track_q <= !tx_q && !wait_sel;
                        txb_q   <= tx_q;
                        stall_q <= !wait_sel;
                    end
                    default: ;
                endcase
            end

            if (slot.ack_rise && txb_q) ackd_q <= !ev.sda;

            if (slot.ack_fall) begin
                ack_q   <= 1'b0;
                track_q <= 1'b0;
                txb_q   <= 1'b0;
                if (phase_q == PH_DATA && wsel_q) stall_q <= 1'b1;
            end
        end
    end

    assign sda_pull   = ack_q;
    assign scl_pull   = stall_q;
    assign rx_byte    = rx_q;
    assign addr_match = match_q;
    assign ext_hit    = ext_q;
    assign busy       = busy_q;
    assign tx_dir     = tx_q;
    assign ack_det    = ackd_q;
endmodule

// File: rtl/i2c_ack_rx.sv
module i2c_ack_rx
    import i2c_ack_pkg::*;
#(
    parameter int unsigned ADDR_W      = I2C_ADDR_W,
    parameter int unsigned DATA_W      = I2C_DATA_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_en,
    input  logic              wait_sel,
    input  logic              wait_rel,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic [DATA_W-1:0] rx_byte,
    output logic              addr_match,
    output logic              ext_hit,
    output logic              busy,
    output logic              tx_dir,
    output logic              ack_det
);
    bus_ev_t           bus_ev;
    slot_ev_t          slot_ev;
    logic [DATA_W-1:0] shreg;

    i2c_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (bus_ev)
    );

    i2c_ack_shift #(.DATA_W(DATA_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .ev    (bus_ev),
        .shreg (shreg),
        .slot  (slot_ev)
    );

    i2c_ack_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .ev         (bus_ev),
        .slot       (slot_ev),
        .shreg      (shreg),
        .own_addr   (own_addr),
        .ack_en     (ack_en),
        .wait_sel   (wait_sel),
        .wait_rel   (wait_rel),
        .sda_pull   (sda_pull),
        .scl_pull   (scl_pull),
        .rx_byte    (rx_byte),
        .addr_match (addr_match),
        .ext_hit    (ext_hit),
        .busy       (busy),
        .tx_dir     (tx_dir),
        .ack_det    (ack_det)
    );
endmodule

// File: rtl/i2c_ack_rx_chk.sv
module i2c_ack_rx_chk
    import i2c_ack_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input bus_ev_t  ev,
    input slot_ev_t slot,
    input logic     wait_rel,
    input logic     sda_pull,
    input logic     scl_pull,
    input logic     addr_match,
    input logic     ext_hit,
    input logic     busy
);
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!busy && !addr_match && !ext_hit && !scl_pull && !sda_pull)); // R1

    AST_ACK_ONLY_ADDRESSED: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> (addr_match || ext_hit)); // R3

    AST_HOLD_IN_TRANSFER: assert property (@(posedge clk) disable iff (rst)
        scl_pull |-> busy); // R7

    AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (scl_pull && wait_rel && !ev.start && !ev.stop) |=> !scl_pull); // R9

    AST_ACK_ENDS: assert property (@(posedge clk) disable iff (rst)
        slot.ack_fall |=> !sda_pull); // R11
endmodule

bind i2c_ack_rx i2c_ack_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev         (bus_ev),
    .slot       (slot_ev),
    .wait_rel   (wait_rel),
    .sda_pull   (sda_pull),
    .scl_pull   (scl_pull),
    .addr_match (addr_match),
    .ext_hit    (ext_hit),
    .busy       (busy)
);

// File: tb/i2c_ack_rx_tb.sv
module i2c_ack_rx_tb;
    localparam int HALF = 10;
    localparam logic [6:0] OWN = 7'h2A;
    // fields: [18:12] address, [11] ack_en, [10] wait_sel, [9:2] data, [1] addr ACK, [0] data ACK
    localparam int NVEC = 8;
    localparam logic [18:0] VEC [0:NVEC-1] = '{
        {7'h2A, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0},
        {7'h2A, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1},
        {7'h15, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0},
        {7'h7A, 1'b0, 1'b1, 8'h81, 1'b0, 1'b0},
        {7'h7A, 1'b1, 1'b1, 8'h81, 1'b1, 1'b1},
        {7'h2A, 1'b1, 1'b0, 8'h5A, 1'b1, 1'b1},
        {7'h2A, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b0},
        {7'h10, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, m_scl, m_sda, ack_en, wait_sel, wait_rel;
    logic sda_pull, scl_pull, addr_match, ext_hit, busy, tx_dir, ack_det;
    logic [7:0] rx_byte;
    logic scl_bus, sda_bus;
    int n_cmp = 0;
    int n_bad = 0;

    assign scl_bus = m_scl & ~scl_pull;
    assign sda_bus = m_sda & ~sda_pull;

    i2c_ack_rx u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_bus), .sda_in(sda_bus),
        .own_addr(OWN), .ack_en(ack_en), .wait_sel(wait_sel), .wait_rel(wait_rel),
        .sda_pull(sda_pull), .scl_pull(scl_pull), .rx_byte(rx_byte),
        .addr_match(addr_match), .ext_hit(ext_hit), .busy(busy),
        .tx_dir(tx_dir), .ack_det(ack_det)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_high;
        while (scl_bus !== 1'b1) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; m_scl = 1'b1; tick(HALF);
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b0; tick(HALF);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b1; wait_high; tick(HALF);
        m_sda = 1'b1; tick(HALF);
    endtask

    // one SCL clock; returns the wired SDA level in the high phase
    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; tick(HALF);
        m_scl = 1'b1; wait_high; tick(HALF/2);
        s = sda_bus; tick(HALF/2);
        m_scl = 1'b0; tick(HALF);
    endtask

    task automatic send8(input logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    endtask

    task automatic release_hold;
        wait_rel = 1'b1; tick(1);
        wait_rel = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic s;
        logic [6:0] a;
        logic aen, wsel, eaa, eda;
        logic [7:0] d;
        rst = 1'b1; m_scl = 1'b1; m_sda = 1'b1;
        ack_en = 1'b0; wait_sel = 1'b1; wait_rel = 1'b0;
        tick(5); rst = 1'b0; tick(3);

        // R1 reset state
        chk("R1", "reset sda_pull", {7'd0, sda_pull}, 8'd0);
        chk("R1", "reset scl_pull", {7'd0, scl_pull}, 8'd0);
        chk("R1", "reset busy", {7'd0, busy}, 8'd0);
        chk("R10", "reset ack_det", {7'd0, ack_det}, 8'd0);

        for (int v = 0; v < NVEC; v++) begin
            a = VEC[v][18:12]; aen = VEC[v][11]; wsel = VEC[v][10];
            d = VEC[v][9:2]; eaa = VEC[v][1]; eda = VEC[v][0];
            ack_en = aen; wait_sel = wsel;
            bus_start;
            chk("R1", "busy after start", {7'd0, busy}, 8'd1);
            send8({a, 1'b0});
            if (!eaa) chk("R3", "no hold on foreign address", {7'd0, scl_pull}, 8'd0);
            if (wsel == 1'b0 && eaa) begin
                chk("R7", "hold after 8th clock", {7'd0, scl_pull}, 8'd1);
                release_hold;
                chk("R9", "hold dropped", {7'd0, scl_pull}, 8'd0);
            end
            if (wsel == 1'b1) chk("R8", "no hold after 8th", {7'd0, scl_pull}, 8'd0);
            clk_bit(1'b1, s);
            chk("R2 R3 R4", "address ack (0=ACK)", {7'd0, s}, {7'd0, ~eaa});
            chk("R2", "addr_match", {7'd0, addr_match}, {7'd0, eaa && a == OWN});
            chk("R4", "ext_hit", {7'd0, ext_hit}, {7'd0, eaa && a != OWN});
            if (eaa) chk("R5", "receive direction", {7'd0, tx_dir}, 8'd0);
            if (wsel == 1'b1 && eaa) begin
                chk("R8", "hold after 9th", {7'd0, scl_pull}, 8'd1);
                release_hold;
            end
            send8(d);
            if (wsel == 1'b0 && eaa) begin
                chk("R7", "hold on data byte", {7'd0, scl_pull}, 8'd1);
                chk("R7", "sda during hold", {7'd0, sda_pull}, {7'd0, eda});
                release_hold;
            end else begin
                chk("R3", "no hold", {7'd0, scl_pull}, {7'd0, 1'b0});
            end
            clk_bit(1'b1, s);
            chk("R6", "data ack (0=ACK)", {7'd0, s}, {7'd0, ~eda});
            if (eaa) chk("R6", "rx_byte", rx_byte, d);
            chk("R11", "sda released after 9th", {7'd0, sda_pull}, 8'd0);
            if (wsel == 1'b1 && eaa) release_hold;
            bus_stop;
            chk("R1", "busy after stop", {7'd0, busy}, 8'd0);
            chk("R1", "match after stop", {7'd0, addr_match}, 8'd0);
            chk("R1", "ext after stop", {7'd0, ext_hit}, 8'd0);
        end

        // R7: enable raised during an eighth-clock hold
        ack_en = 1'b0; wait_sel = 1'b0;
        bus_start;
        send8({OWN, 1'b0});
        release_hold;
        clk_bit(1'b1, s);
        chk("R2", "own address ACK with ack_en=0", {7'd0, s}, 8'd0);
        send8(8'h99);
        chk("R7", "no ack before enable", {7'd0, sda_pull}, 8'd0);
        ack_en = 1'b1; tick(2);
        chk("R7", "ack follows enable in hold", {7'd0, sda_pull}, 8'd1);
        release_hold;
        clk_bit(1'b1, s);
        chk("R7", "late enable ACK", {7'd0, s}, 8'd0);
        chk("R6", "rx_byte late enable", rx_byte, 8'h99);
        bus_stop;

        // R8: ack taken at eighth falling edge
        ack_en = 1'b0; wait_sel = 1'b1;
        bus_start;
        send8({OWN, 1'b0});
        clk_bit(1'b1, s);
        ack_en = 1'b1;
        release_hold;
        send8(8'h42);
        ack_en = 1'b0;
        clk_bit(1'b1, s);
        chk("R8", "enable cleared after 8th fall still ACK", {7'd0, s}, 8'd0);
        chk("R8", "hold after 9th data", {7'd0, scl_pull}, 8'd1);
        release_hold;
        send8(8'h43);
        ack_en = 1'b1;
        clk_bit(1'b1, s);
        chk("R8", "enable set after 8th fall gives NACK", {7'd0, s}, 8'd1);
        release_hold;
        bus_stop;

        // R5 / R10: transmit direction
        ack_en = 1'b1; wait_sel = 1'b1;
        bus_start;
        send8({OWN, 1'b1});
        clk_bit(1'b1, s);
        chk("R5", "tx_dir set", {7'd0, tx_dir}, 8'd1);
        release_hold;
        send8(8'hFF);
        chk("R10", "no sda drive in transmit", {7'd0, sda_pull}, 8'd0);
        clk_bit(1'b0, s);
        chk("R10", "ack_det after ACK", {7'd0, ack_det}, 8'd1);
        release_hold;
        send8(8'hFF);
        clk_bit(1'b1, s);
        chk("R10", "ack_det after NACK", {7'd0, ack_det}, 8'd0);
        release_hold;
        bus_stop;
        chk("R1", "busy after final stop", {7'd0, busy}, 8'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule